// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

A behavioural, synthesizable single-clock synchronous memory. Address, chip selects, the two address-load strobes, the burst-advance strobe, the write enables and the write data are all captured on the rising clock edge. The captured address drives the storage array directly, with no register after it. Read data therefore appears combinationally in the same cycle the address was taken. An asynchronous output-enable input gates the read data.

A burst starts when either load strobe is low. One strobe is for a processor and one is for a cache controller, and the two behave the same way. A 2-bit beat counter then supplies the two low address bits. The order is selected by `order_lin`: 0 gives interleaved order and 1 gives linear order. Writes can cover the whole word or single bytes. Three chip selects allow depth expansion. A sleep input freezes all internal state. A small parameterised array stands in for the storage core.

Top module: `sync_burst_sram`

## Requirements
- R1: After a clock edge with `rst_n` low, `dq_oe` is 0 and `rdata` is 0. They stay so until a selected load.
- R2: At a clock edge where `sleep` is 0 and `ld_proc_n` or `ld_ctrl_n` is low, `addr` is loaded as the burst start. Beat 0 reads the stored word at `addr` in the cycle after that edge, with no further clock.
- R3: With `order_lin` = 0 (interleaved), beat k reads low address bits `start[1:0] XOR k`. Start 1 gives 1,0,3,2 and then wraps to 1. Bits above bit 1 never change during a burst.
- R4: With `order_lin` = 1 (linear), beat k reads low address bits `(start[1:0] + k) mod 4`. Start 1 gives 1,2,3,0 and start 3 gives 3,0,1,2. Bits above bit 1 never change.
- R5: The beat advances only at an edge with `adv_n` low and both load strobes high. A load at the same edge as `adv_n` low wins and restarts at beat 0. With all three strobes high, the address holds.
- R6: A load selects the device only if `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0 at that edge. After an unselected load, `dq_oe` and `rdata` stay 0 and no write takes effect until the next selected load.
- R7: At an edge where `gwr_n` is 0, all bytes of the current address are written from `wdata`, whatever `bwe_n` and `be_n` are.
- R8: With `gwr_n` = 1, byte i (bits 8i+7..8i) is written only if `bwe_n` = 0 and `be_n[i]` = 0. With `bwe_n` = 1, nothing is written.
- R9: `oe_n` = 1 forces `dq_oe` = 0 and `rdata` = 0 at once, with no clock. `oe_n` = 0 restores the read data at once.
- R10: While `sleep` = 1, `dq_oe` and `rdata` are 0 and no load, advance or write takes effect. After `sleep` returns to 0, the address, burst position and selection are as they were before sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | Word address loaded at burst start |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| ld_proc_n | input | 1 | Processor address load strobe, active low |
| ld_ctrl_n | input | 1 | Controller address load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Whole-word write, active low |
| bwe_n | input | 1 | Byte write gate, active low |
| be_n | input | NB | Per-byte write enables, active low |
| wdata | input | NB*BW | Write data |
| order_lin | input | 1 | Burst order: 0 interleaved, 1 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Freeze all activity, active high |
| rdata | output | NB*BW | Read data, 0 when not driven |
| dq_oe | output | 1 | Read data is being driven |

## Verification
The read path has no register after the array, so a wrong burst position or base address shows on `rdata` in the very cycle after the edge that caused it. A wrong selection flag or a leak through sleep shows on `dq_oe` in that same cycle. A misdirected byte write stays hidden until the affected word is read back. For that reason the bench re-reads every word it has written, in both burst orders and after deselected and sleeping cycles. It compares each cycle against a behavioural model that tracks which bytes it knows.

// File: rtl/sbs_pkg.sv
// Package: shared types and the burst-order address function for the
// flow-through burst memory. Assumes bursts are four beats long.
package sbs_pkg;

    // Burst sequence selected by the order input
    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

    localparam int unsigned BEAT_W = 2;

    // Low address bits for a given start and beat in the selected order
    function automatic logic [BEAT_W-1:0] burst_low(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input burst_order_e      ord
    );
        logic [BEAT_W-1:0] r;
        if (ord == ORD_LINEAR) begin
            r = start + beat;
        end else begin
            r = start ^ beat;
        end
        return r;
    endfunction

endpackage

// File: rtl/sbs_burst_ctr.sv
// Burst address generator. It holds the loaded start address and a 2-bit
// beat count, and it forms the current address and the address after this
// edge. Assumes AW >= 3 and that the order input is steady within a burst.
module sbs_burst_ctr
    import sbs_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          freeze,
    input  logic          load,
    input  logic          step,
    input  logic          ord,
    input  logic [AW-1:0] ld_addr,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);

    localparam int unsigned HI_W = AW - BEAT_W;

    logic [AW-1:0]     base_q;
    logic [AW-1:0]     base_d;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beat_d;
    burst_order_e      ord_e;

    assign ord_e = burst_order_e'(ord);

    // Next base and beat: a load wins over an advance, and freeze holds both
    always_comb begin
        base_d = base_q;
        beat_d = beat_q;
        if (!freeze) begin
            if (load) begin
                base_d = ld_addr;
                beat_d = '0;
            end else if (step) begin
                beat_d = beat_q + 1'b1;
            end
        end
    end

    // Base and beat registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else begin
            base_q <= base_d;
            beat_q <= beat_d;
        end
    end

    // Address that the array sees now, and the one it sees after this edge
    assign cur_addr = {base_q[AW-1 -: HI_W], burst_low(base_q[BEAT_W-1:0], beat_q, ord_e)};
    assign nxt_addr = {base_d[AW-1 -: HI_W], burst_low(base_d[BEAT_W-1:0], beat_d, ord_e)};

endmodule

// File: rtl/sbs_sel_ctl.sv
// Selection state. A load latches whether all three chip selects were
// active. Freeze holds the flag. Assumes a load is the only event that
// changes selection.
module sbs_sel_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic freeze,
    input  logic load,
    input  logic ce_a_n,
    input  logic ce_b,
    input  logic ce_c_n,
    output logic sel_q,
    output logic sel_d
);

    logic all_sel;

    assign all_sel = !ce_a_n && ce_b && !ce_c_n;

    // Next selection: only an unfrozen load updates it
    always_comb begin
        sel_d = sel_q;
        if (!freeze && load) begin
            sel_d = all_sel;
        end
    end

    // Selection register with synchronous reset to deselected
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= sel_d;
        end
    end

endmodule

// File: rtl/sbs_wr_decode.sv
// Write lane decode. The whole-word write overrides the byte enables. A
// byte lane is written when the byte gate and its own enable are both low.
// Assumes 'active' already includes selection and the absence of sleep.
module sbs_wr_decode #(
    parameter int unsigned NB = 4
) (
    input  logic          active,
    input  logic          gwr_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] be_n,
    output logic [NB-1:0] lane_we
);

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_lane
            // Per-lane enable with whole-word priority
            always_comb begin
                lane_we[g] = active && (!gwr_n || (!bwe_n && !be_n[g]));
            end
        end
    endgenerate

endmodule

// File: rtl/sbs_core.sv
// Storage array built as one memory per byte lane. Writes happen at the
// clock edge; the read is asynchronous, which gives the flow-through path.
// Assumes the storage has no reset.
module sbs_core #(
    parameter int unsigned AW = 8,
    parameter int unsigned NB = 4,
    parameter int unsigned BW = 8
) (
    input  logic             clk,
    input  logic [NB-1:0]    lane_we,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NB*BW-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [NB*BW-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << AW;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_lane
            logic [BW-1:0] mem [DEPTH];

            // Lane write at the clock edge
            always_ff @(posedge clk) begin
                if (lane_we[g]) begin
                    mem[wr_addr] <= wr_data[g*BW +: BW];
                end
            end

            // Lane read with no output register
            assign rd_data[g*BW +: BW] = mem[rd_addr];
        end
    endgenerate

endmodule

// File: rtl/sync_burst_sram.sv
// Top level: synchronous flow-through burst memory. All control and data
// inputs take effect at the rising edge. Read data follows the registered
// address in the same cycle and is gated asynchronously by oe_n. Assumes
// order_lin is steady while a burst is in progress.
module sync_burst_sram #(
    parameter int unsigned AW = 8,
    parameter int unsigned NB = 4,
    parameter int unsigned BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             ce_a_n,
    input  logic             ce_b,
    input  logic             ce_c_n,
    input  logic             ld_proc_n,
    input  logic             ld_ctrl_n,
    input  logic             adv_n,
    input  logic             gwr_n,
    input  logic             bwe_n,
    input  logic [NB-1:0]    be_n,
    input  logic [NB*BW-1:0] wdata,
    input  logic             order_lin,
    input  logic             oe_n,
    input  logic             sleep,
    output logic [NB*BW-1:0] rdata,
    output logic             dq_oe
);

    localparam int unsigned DW = NB * BW;

    logic          load;
    logic          step;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] nxt_addr;
    logic          sel_q;
    logic          sel_d;
    logic          wr_active;
    logic [NB-1:0] lane_we;
    logic [DW-1:0] core_rd;

    assign load = !ld_proc_n || !ld_ctrl_n;
    assign step = !adv_n;

    sbs_burst_ctr #(.AW(AW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze   (sleep),
        .load     (load),
        .step     (step),
        .ord      (order_lin),
        .ld_addr  (addr),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr)
    );

    sbs_sel_ctl u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (sleep),
        .load   (load),
        .ce_a_n (ce_a_n),
        .ce_b   (ce_b),
        .ce_c_n (ce_c_n),
        .sel_q  (sel_q),
        .sel_d  (sel_d)
    );

    // Writes land at the address after this edge while selected and awake
    assign wr_active = sel_d && !sleep && rst_n;

    sbs_wr_decode #(.NB(NB)) u_wdec (
        .active  (wr_active),
        .gwr_n   (gwr_n),
        .bwe_n   (bwe_n),
        .be_n    (be_n),
        .lane_we (lane_we)
    );

    sbs_core #(.AW(AW), .NB(NB), .BW(BW)) u_core (
        .clk     (clk),
        .lane_we (lane_we),
        .wr_addr (nxt_addr),
        .wr_data (wdata),
        .rd_addr (cur_addr),
        .rd_data (core_rd)
    );

    // Output gate: asynchronous enable, selection and sleep
    always_comb begin
        dq_oe = !oe_n && sel_q && !sleep;
        rdata = dq_oe ? core_rd : '0;
    end

endmodule

// File: rtl/sbs_checker.sv
// Checker for sync_burst_sram, attached with bind. It relates the input
// strobes to the registered address and to the output gate over time.
module sbs_checker #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          ce_a_n,
    input logic          ce_b,
    input logic          ce_c_n,
    input logic          ld_proc_n,
    input logic          ld_ctrl_n,
    input logic          adv_n,
    input logic          oe_n,
    input logic          sleep,
    input logic [DW-1:0] rdata,
    input logic          dq_oe,
    input logic [AW-1:0] cur_addr
);

    // R1: the first cycle after reset release does not drive
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dq_oe);

    // R2: a load presents the given address
    p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && (!ld_proc_n || !ld_ctrl_n)) |=> (cur_addr == $past(addr)));

    // R3 and R4: an advance keeps the upper address bits
    p_adv_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && ld_proc_n && ld_ctrl_n && !adv_n)
        |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

    // R5: no strobe keeps the address
    p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && ld_proc_n && ld_ctrl_n && adv_n) |=> $stable(cur_addr));

    // R6: an unselected load silences the outputs
    p_desel_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && (!ld_proc_n || !ld_ctrl_n) && !(!ce_a_n && ce_b && !ce_c_n))
        |=> !dq_oe);

    // R9: raising the output enable silences the outputs
    p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (!dq_oe && (rdata == '0)));

    // R10: sleep freezes the address
    p_sleep_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(cur_addr));

endmodule

bind sync_burst_sram sbs_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .ce_a_n    (ce_a_n),
    .ce_b      (ce_b),
    .ce_c_n    (ce_c_n),
    .ld_proc_n (ld_proc_n),
    .ld_ctrl_n (ld_ctrl_n),
    .adv_n     (adv_n),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .rdata     (rdata),
    .dq_oe     (dq_oe),
    .cur_addr  (cur_addr)
);

// File: tb/sync_burst_sram_test.sv
`timescale 1ns/100ps
// Bench for sync_burst_sram: directed stimulus, a behavioural reference
// model that is compared after every clock, and named checks per requirement.
module sync_burst_sram_test;

    localparam int AW = 8;
    localparam int NB = 4;
    localparam int BW = 8;
    localparam int DW = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_a_n = 1'b0, ce_b = 1'b1, ce_c_n = 1'b0;
    logic          ld_proc_n = 1'b1, ld_ctrl_n = 1'b1, adv_n = 1'b1;
    logic          gwr_n = 1'b1, bwe_n = 1'b1;
    logic [NB-1:0] be_n = '1;
    logic [DW-1:0] wdata = '0;
    logic          order_lin = 1'b0, oe_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0] rdata;
    logic          dq_oe;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;

    // Reference model state
    int            m_base = 0;
    int            m_beat = 0;
    bit            m_sel = 0;
    logic [DW-1:0] m_mem   [DEPTH];
    logic [DW-1:0] m_known [DEPTH];

    sync_burst_sram #(.AW(AW), .NB(NB), .BW(BW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .ld_proc_n(ld_proc_n), .ld_ctrl_n(ld_ctrl_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwe_n(bwe_n), .be_n(be_n), .wdata(wdata),
        .order_lin(order_lin), .oe_n(oe_n), .sleep(sleep),
        .rdata(rdata), .dq_oe(dq_oe)
    );

    always #2 clk = ~clk;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_mem[i] = '0;
            m_known[i] = '0;
        end
    end

    // Model address from start and beat
    function automatic int m_addr();
        int lo;
        if (order_lin) lo = ((m_base % 4) + m_beat) % 4;
        else           lo = (m_base % 4) ^ m_beat;
        return (m_base / 4) * 4 + lo;
    endfunction

    // Model update at every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = 0; m_beat = 0; m_sel = 0;
        end else if (!sleep) begin
            if (!ld_proc_n || !ld_ctrl_n) begin
                m_base = int'(addr); m_beat = 0;
                m_sel = (!ce_a_n && ce_b && !ce_c_n);
            end else if (!adv_n) begin
                m_beat = (m_beat + 1) % 4;
            end
            if (m_sel) begin
                for (int b = 0; b < NB; b++) begin
                    if (!gwr_n || (!bwe_n && !be_n[b])) begin
                        m_mem[m_addr()][b*BW +: BW] = wdata[b*BW +: BW];
                        m_known[m_addr()][b*BW +: BW] = '1;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare outputs against the model
    task automatic model_cmp();
        bit eoe;
        logic [DW-1:0] msk;
        eoe = rst_n && !oe_n && m_sel && !sleep;
        check(dq_oe === eoe, "model dq_oe (R1 R6 R9 R10)", {{(DW-1){1'b0}}, dq_oe}, {{(DW-1){1'b0}}, eoe});
        if (eoe) begin
            msk = m_known[m_addr()];
            check(((rdata ^ m_mem[m_addr()]) & msk) == '0, "model rdata (R2 R3 R4 R7 R8)",
                  rdata, m_mem[m_addr()]);
        end else begin
            check(rdata === '0, "model rdata idle", rdata, '0);
        end
    endtask

    // One clock: inputs were set after a falling edge; compare at the next one
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        model_cmp();
    endtask

    task automatic expect_out(input bit eoe, input logic [DW-1:0] ed, input string tag);
        check(dq_oe === eoe, {tag, " dq_oe"}, {{(DW-1){1'b0}}, dq_oe}, {{(DW-1){1'b0}}, eoe});
        check(rdata === ed, {tag, " rdata"}, rdata, ed);
    endtask

    task automatic idle();
        ld_proc_n = 1; ld_ctrl_n = 1; adv_n = 1; gwr_n = 1; bwe_n = 1; be_n = '1;
        ce_a_n = 0; ce_b = 1; ce_c_n = 0;
    endtask

    task automatic ld(input logic [AW-1:0] a, input bit proc);
        addr = a; ld_proc_n = !proc; ld_ctrl_n = proc;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        expect_out(0, '0, "R1 after reset");

        // R2 + R7: load through the processor strobe with a whole-word write
        idle(); ld(8'h10, 1); gwr_n = 0; wdata = 32'hA5A5_0001; cyc();
        expect_out(1, 32'hA5A5_0001, "R2 R7 load+write");
        idle(); cyc();
        expect_out(1, 32'hA5A5_0001, "R5 hold");

        // Fill words 0x20..0x23
        for (int k = 0; k < 4; k++) begin
            idle(); ld(8'h20 + k[7:0], k[0]); gwr_n = 0; wdata = 32'h1000 + k; cyc();
        end

        // R3: interleaved from start 1
        idle(); order_lin = 0; ld(8'h21, 0); cyc();
        expect_out(1, 32'h1001, "R2 ctrl load");
        idle(); adv_n = 0; cyc(); expect_out(1, 32'h1000, "R3 beat1");
        cyc(); expect_out(1, 32'h1003, "R3 beat2");
        cyc(); expect_out(1, 32'h1002, "R3 beat3");
        cyc(); expect_out(1, 32'h1001, "R3 wrap");

        // R4: linear from start 1 and from start 3
        idle(); order_lin = 1; ld(8'h21, 1); cyc();
        idle(); adv_n = 0; cyc(); expect_out(1, 32'h1002, "R4 beat1");
        cyc(); cyc(); expect_out(1, 32'h1000, "R4 beat3");
        idle(); ld(8'h23, 0); cyc(); expect_out(1, 32'h1003, "R4 start3");
        idle(); adv_n = 0; cyc(); expect_out(1, 32'h1000, "R4 wrap low bits");

        // R5: load wins over advance, then hold
        idle(); adv_n = 0; ld(8'h22, 1); cyc(); expect_out(1, 32'h1002, "R5 load wins");
        idle(); cyc(); cyc(); expect_out(1, 32'h1002, "R5 hold two cycles");

        // R8: byte lanes 0 and 2 written
        idle(); ld(8'h20, 1); bwe_n = 0; be_n = 4'b1010; wdata = 32'hFFFF_FFFF; cyc();
        expect_out(1, 32'h00FF_10FF, "R8 byte lanes");
        // R8: gate high blocks byte writes
        idle(); ld(8'h21, 1); bwe_n = 1; be_n = 4'b0000; wdata = 32'hFFFF_FFFF; cyc();
        expect_out(1, 32'h0000_1001, "R8 gate blocks");
        // R7: whole word overrides
        idle(); ld(8'h22, 0); gwr_n = 0; bwe_n = 1; be_n = '1; wdata = 32'h1234_5678; cyc();
        expect_out(1, 32'h1234_5678, "R7 whole word");

        // R6: unselected loads
        idle(); ld(8'h20, 1); ce_b = 0; gwr_n = 0; wdata = 32'hDEAD_BEEF; cyc();
        expect_out(0, '0, "R6 ce_b low");
        idle(); adv_n = 0; gwr_n = 0; wdata = 32'hDEAD_BEEF; cyc();
        expect_out(0, '0, "R6 stays deselected");
        idle(); ld(8'h20, 0); ce_a_n = 1; gwr_n = 0; cyc();
        expect_out(0, '0, "R6 ce_a_n high");
        idle(); ld(8'h20, 1); ce_c_n = 1; cyc();
        expect_out(0, '0, "R6 ce_c_n high");
        idle(); ld(8'h20, 1); cyc();
        expect_out(1, 32'h00FF_10FF, "R6 no write while deselected");

        // R9: asynchronous output enable
        idle(); cyc();
        oe_n = 1; #0.5;
        expect_out(0, '0, "R9 oe off");
        oe_n = 0; #0.5;
        expect_out(1, 32'h00FF_10FF, "R9 oe on");

        // R10: sleep freezes everything
        sleep = 1; #0.5;
        expect_out(0, '0, "R10 sleep quiet");
        ld(8'h22, 1); gwr_n = 0; wdata = 32'h0000_BAD0; cyc();
        idle(); adv_n = 0; gwr_n = 0; wdata = 32'h0000_BAD0; cyc();
        expect_out(0, '0, "R10 still quiet");
        idle(); sleep = 0; #0.5;
        expect_out(1, 32'h00FF_10FF, "R10 resume position");
        cyc();
        ld(8'h22, 0); cyc();
        expect_out(1, 32'h1234_5678, "R10 write ignored");

        // R1: reset again clears selection
        idle(); rst_n = 0; cyc();
        rst_n = 1; cyc();
        expect_out(0, '0, "R1 reset mid-run");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule